// File: doc/BRIEF.md
# Flash Unlock and Mode-Register Guard

This block is the register front end that sits between a byte-wide processor bus and a flash programming sequencer. It protects the two flash areas, program memory and data memory, behind a two-write key sequence each. It also guards the programming mode byte, so that a single stray store cannot change the mode. A new mode reaches the sequencer only when a mode byte and its bitwise complement have both been written, in either order. Two bits of both mode registers are held by hardware and cannot be changed by software.

The sequencer reports completion and refused writes by pulsing two inputs. These pulses set sticky flags in a status register. Reading the status register hands software the flags and clears them. One interrupt line covers both flags and is gated by an enable bit in a control register. The register offsets are 0 control, 1 mode, 2 mode complement, 3 status, 4 program key, 5 data key. Offsets 6 and 7 read as zero and ignore writes.

Top module: `flash_guard`

## Requirements
- R1: After reset, control reads 0x00, mode reads 0x00, mode complement reads 0xFF and status reads 0x40. The applied mode output is 0x00 and the interrupt is low.
- R2: A write to the mode register (offset 1) always stores the value. The value reaches the applied mode output only if the complement register already holds its bitwise inverse.
- R3: A write to the complement register (offset 2) always stores the value. If the mode register already equals its inverse, the inverse of the written value reaches the applied mode output.
- R4: Bits 5 and 4 of both the mode and the complement registers keep their previous values on every write. After reset they are 00 in the mode register and 11 in the complement register.
- R5: Writing 0x56 and then 0xAE to the program key register (offset 4) opens program memory. This sets status bit 1 and the program-open output.
- R6: Writing 0xAE and then 0x56 to the data key register (offset 5) opens data memory. This sets status bit 3 and the data-open output.
- R7: A key write with the wrong value, in either step of the sequence, fails that area. A failed area stays locked, whatever keys are written later, until reset.
- R8: Writing the status register with bit 1 (or bit 3) at 0 relocks that area and discards a half-entered key. Writing those bits at 1 has no effect.
- R9: A read of status (offset 3) returns the current value and then clears the end-of-program flag (bit 2) and the write-refused flag (bit 0). A set pulse in the same cycle as that read wins over the clear.
- R10: The interrupt is high exactly while control bit 1 is set and at least one of the status bits 2 and 0 is set.
- R11: Read data appears on the read-data port one cycle after the read request. Offsets 4 to 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read |
| eop_set_i | input | 1 | Sequencer pulse: programming finished |
| wrdis_set_i | input | 1 | Sequencer pulse: write refused |
| mode_o | output | 8 | Mode byte accepted by the complement check |
| prog_open_o | output | 1 | Program memory unlocked |
| data_open_o | output | 1 | Data memory unlocked |
| irq_o | output | 1 | Shared flag interrupt |

## Verification
Register writes take effect at the clock edge that samples them. The unlock outputs, the applied mode and the interrupt are therefore checked at the falling edge that follows the write cycle. Read data is due one edge after the request. The bench records each expected read value in a queue when it issues the read. A monitor pops and compares that value at the next falling edge, and only when a read was issued in the cycle before. A flag cleared by a status read is confirmed by a second status read. That second read shows the cleared value, and the interrupt is sampled after that read's edge. In the case where a read and a set pulse coincide, the first read must show the old status and the following read the new one.

// File: rtl/flash_guard_pkg.sv
// Shared constants and types for the flash register guard.
// Assumes a byte-wide bus with eight register offsets.
package flash_guard_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_NMODE = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_PKEY  = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DKEY  = 3'd5;

    localparam int STAT_WRDIS = 0;
    localparam int STAT_POPEN = 1;
    localparam int STAT_EOP   = 2;
    localparam int STAT_DOPEN = 3;
    localparam int STAT_IDLE  = 6;
    localparam int CTRL_IE    = 1;

    localparam int NUM_AREAS = 2;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2,
        GATE_FAILED = 2'd3
    } gate_state_t;
endpackage

// File: rtl/flash_key_gate.sv
// Two-step key gate for one memory area.
// A correct first key arms the gate and a correct second key opens it.
// Any wrong key fails the gate, and it stays failed until reset.
// A relock request returns an armed or open gate to locked.
// Assumes that key_we and relock are never both high in one cycle.
module flash_key_gate
    import flash_guard_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h56,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hAE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_val,
    input  logic              relock,
    output logic              is_open,
    output logic              is_failed
);
    gate_state_t state_q, state_d;

    // Next-state rule for key writes and relock requests.
    always_comb begin
        state_d = state_q;
        if (relock) begin
            if (state_q != GATE_FAILED) state_d = GATE_LOCKED;
        end else if (key_we) begin
            unique case (state_q)
                GATE_LOCKED: state_d = (key_val == KEY_FIRST)  ? GATE_ARMED : GATE_FAILED;
                GATE_ARMED:  state_d = (key_val == KEY_SECOND) ? GATE_OPEN  : GATE_FAILED;
                default:     state_d = state_q;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_LOCKED;
        else        state_q <= state_d;
    end

    assign is_open   = (state_q == GATE_OPEN);
    assign is_failed = (state_q == GATE_FAILED);
endmodule

// File: rtl/flash_mode_guard.sv
// Holds the mode byte and its complement and forwards a mode only when
// the two registers agree bitwise. The bits in KEEP_MASK cannot be changed
// by software. Assumes that mode_we and nmode_we are never both high.
module flash_mode_guard
    import flash_guard_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEEP_MASK = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              nmode_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] nmode_q,
    output logic [DATA_W-1:0] mode_applied
);
    logic [DATA_W-1:0] mode_in, nmode_in;

    // Merge write data with the held bits of each register.
    always_comb begin
        mode_in  = (wdata & ~KEEP_MASK) | (mode_q  & KEEP_MASK);
        nmode_in = (wdata & ~KEEP_MASK) | (nmode_q & KEEP_MASK);
    end

    // Store writes and apply a mode when its complement already matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= '0;
            nmode_q      <= '1;
            mode_applied <= '0;
        end else begin
            if (mode_we) begin
                mode_q <= mode_in;
                if (nmode_q == ~mode_in) mode_applied <= mode_in;
            end
            if (nmode_we) begin
                nmode_q <= nmode_in;
                if (mode_q == ~nmode_in) mode_applied <= ~nmode_in;
            end
        end
    end
endmodule

// File: rtl/flash_status_flags.sv
// Sticky end-of-program and write-refused flags.
// A set pulse wins over a read-clear that arrives in the same cycle.
module flash_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic eop_set,
    input  logic wrdis_set,
    input  logic rd_clear,
    output logic eop_q,
    output logic wrdis_q
);
    // Set on a pulse, clear on a status read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_q   <= 1'b0;
            wrdis_q <= 1'b0;
        end else begin
            eop_q   <= eop_set   | (eop_q   & ~rd_clear);
            wrdis_q <= wrdis_set | (wrdis_q & ~rd_clear);
        end
    end
endmodule

// File: rtl/flash_guard.sv
// Register front end of the flash controller. It decodes the byte bus,
// runs the two key gates, guards the mode byte and keeps the status flags.
// Reads return data one cycle after the request.
// Assumes one access per cycle and single-cycle sequencer pulses.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter logic [DATA_W-1:0] PKEY_FIRST  = 8'h56,
    parameter logic [DATA_W-1:0] PKEY_SECOND = 8'hAE,
    parameter logic [DATA_W-1:0] DKEY_FIRST  = 8'hAE,
    parameter logic [DATA_W-1:0] DKEY_SECOND = 8'h56,
    parameter logic [DATA_W-1:0] MODE_KEEP   = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eop_set_i,
    input  logic              wrdis_set_i,
    output logic [DATA_W-1:0] mode_o,
    output logic              prog_open_o,
    output logic              data_open_o,
    output logic              irq_o
);
    logic wr_ctrl, wr_mode, wr_nmode, wr_stat, rd_stat;
    logic [NUM_AREAS-1:0] gate_we, gate_relock, gate_open, gate_failed;
    logic [DATA_W-1:0] ctrl_q, mode_q, nmode_q, stat_val, rd_mux;
    logic eop_q, wrdis_q;

    // Decode the bus access into per-register strobes.
    always_comb begin
        wr_ctrl  = bus_en & bus_we & (bus_addr == OFF_CTRL);
        wr_mode  = bus_en & bus_we & (bus_addr == OFF_MODE);
        wr_nmode = bus_en & bus_we & (bus_addr == OFF_NMODE);
        wr_stat  = bus_en & bus_we & (bus_addr == OFF_STAT);
        rd_stat  = bus_en & ~bus_we & (bus_addr == OFF_STAT);
        gate_we[0] = bus_en & bus_we & (bus_addr == OFF_PKEY);
        gate_we[1] = bus_en & bus_we & (bus_addr == OFF_DKEY);
        gate_relock[0] = wr_stat & ~bus_wdata[STAT_POPEN];
        gate_relock[1] = wr_stat & ~bus_wdata[STAT_DOPEN];
    end

    // One key gate per memory area, with its own key pair.
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_gate
        localparam logic [DATA_W-1:0] K1 = (g == 0) ? PKEY_FIRST  : DKEY_FIRST;
        localparam logic [DATA_W-1:0] K2 = (g == 0) ? PKEY_SECOND : DKEY_SECOND;
        flash_key_gate #(
            .KEY_FIRST (K1),
            .KEY_SECOND(K2)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_we   (gate_we[g]),
            .key_val  (bus_wdata),
            .relock   (gate_relock[g]),
            .is_open  (gate_open[g]),
            .is_failed(gate_failed[g])
        );
    end

    flash_mode_guard #(
        .KEEP_MASK(MODE_KEEP)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_we     (wr_mode),
        .nmode_we    (wr_nmode),
        .wdata       (bus_wdata),
        .mode_q      (mode_q),
        .nmode_q     (nmode_q),
        .mode_applied(mode_o)
    );

    flash_status_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .eop_set  (eop_set_i),
        .wrdis_set(wrdis_set_i),
        .rd_clear (rd_stat),
        .eop_q    (eop_q),
        .wrdis_q  (wrdis_q)
    );

    // Control register, fully writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    // Assemble the status byte from the gates and the flags.
    always_comb begin
        stat_val             = '0;
        stat_val[STAT_IDLE]  = 1'b1;
        stat_val[STAT_DOPEN] = gate_open[1];
        stat_val[STAT_EOP]   = eop_q;
        stat_val[STAT_POPEN] = gate_open[0];
        stat_val[STAT_WRDIS] = wrdis_q;
    end

    // Read multiplexer. Key and unused offsets read zero.
    always_comb begin
        unique case (bus_addr)
            OFF_CTRL:  rd_mux = ctrl_q;
            OFF_MODE:  rd_mux = mode_q;
            OFF_NMODE: rd_mux = nmode_q;
            OFF_STAT:  rd_mux = stat_val;
            default:   rd_mux = '0;
        endcase
    end

    // Register the read data, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_mux;
    end

    assign prog_open_o = gate_open[0];
    assign data_open_o = gate_open[1];
    assign irq_o       = ctrl_q[CTRL_IE] & (eop_q | wrdis_q);
endmodule

// File: rtl/flash_guard_chk.sv
// Assertion checker for flash_guard, attached to it by bind.
module flash_guard_chk
    import flash_guard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              eop_set_i,
    input logic              wrdis_set_i,
    input logic [DATA_W-1:0] mode_o,
    input logic              prog_open_o,
    input logic              data_open_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] nmode_q,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              eop_q,
    input logic              wrdis_q,
    input logic [1:0]        gate_failed
);
    logic seen = 1'b0;

    // Marks that at least one reset edge has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b1;
    end

    p_mode_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && mode_o != $past(mode_o)) |->
        $past(bus_en && bus_we && (bus_addr == OFF_MODE || bus_addr == OFF_NMODE)));

    p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ($stable(mode_q[5:4]) && $stable(nmode_q[5:4])));

    p_prog_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(prog_open_o)) |->
        $past(bus_en && bus_we && bus_addr == OFF_PKEY && bus_wdata == 8'hAE));

    p_data_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(data_open_o)) |->
        $past(bus_en && bus_we && bus_addr == OFF_DKEY && bus_wdata == 8'h56));

    p_failed_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_failed[0] |-> !prog_open_o) and (gate_failed[1] |-> !data_open_o));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(bus_en && !bus_we && bus_addr == OFF_STAT)) |->
        ((eop_q == $past(eop_set_i)) && (wrdis_q == $past(wrdis_set_i))));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(eop_set_i)) |-> eop_q);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctrl_q[CTRL_IE] && (eop_q || wrdis_q)));
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .eop_set_i  (eop_set_i),
    .wrdis_set_i(wrdis_set_i),
    .mode_o     (mode_o),
    .prog_open_o(prog_open_o),
    .data_open_o(data_open_o),
    .irq_o      (irq_o),
    .mode_q     (mode_q),
    .nmode_q    (nmode_q),
    .ctrl_q     (ctrl_q),
    .eop_q      (eop_q),
    .wrdis_q    (wrdis_q),
    .gate_failed(gate_failed)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       eop_set_i = 1'b0;
    logic       wrdis_set_i = 1'b0;
    logic [7:0] mode_o;
    logic       prog_open_o, data_open_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_issued = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eop_set_i(eop_set_i), .wrdis_set_i(wrdis_set_i), .mode_o(mode_o),
        .prog_open_o(prog_open_o), .data_open_o(data_open_o), .irq_o(irq_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string rid);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", rid, act, exp);
        end
    endtask

    // Bench-side record that a read was sampled at the last edge.
    always @(posedge clk) rd_issued <= rst_n && bus_en && !bus_we;

    // Monitor: compares read data one cycle after each read.
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected read data actual=%02h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string rid);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(rid);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input bit eop, input bit wrdis);
        @(negedge clk);
        eop_set_i = eop; wrdis_set_i = wrdis;
        @(negedge clk);
        eop_set_i = 1'b0; wrdis_set_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(3'd0, 8'h00, "R1 ctrl");
        rd(3'd1, 8'h00, "R1 mode");
        rd(3'd2, 8'hFF, "R1 nmode");
        rd(3'd3, 8'h40, "R1 status");
        chk(mode_o, 8'h00, "R1 mode_o");
        chk({7'd0, irq_o}, 8'h00, "R1 irq");

        // R4 held bits, R2 no apply without complement
        wr(3'd1, 8'hFF);
        chk(mode_o, 8'h00, "R2 no apply");
        rd(3'd1, 8'hCF, "R4 mode held bits");
        // R3 complement write applies
        wr(3'd2, 8'h30);
        rd(3'd2, 8'h30, "R4 nmode held bits");
        chk(mode_o, 8'hCF, "R3 apply via complement");
        wr(3'd1, 8'h01);
        chk(mode_o, 8'hCF, "R2 mismatch keeps mode");
        wr(3'd2, 8'hFE);
        chk(mode_o, 8'h01, "R3 apply second");
        wr(3'd2, 8'hFB);
        chk(mode_o, 8'h01, "R3 mismatch keeps mode");
        wr(3'd1, 8'h04);
        chk(mode_o, 8'h04, "R2 apply via mode write");

        // R5 program key
        wr(3'd4, 8'h56);
        chk({7'd0, prog_open_o}, 8'h00, "R5 armed not open");
        wr(3'd4, 8'hAE);
        chk({7'd0, prog_open_o}, 8'h01, "R5 open");
        rd(3'd3, 8'h42, "R5 status");
        rd(3'd4, 8'h00, "R11 key reads zero");
        // R6 data key
        wr(3'd5, 8'hAE);
        wr(3'd5, 8'h56);
        chk({7'd0, data_open_o}, 8'h01, "R6 open");
        rd(3'd3, 8'h4A, "R6 status");

        // R8 relock
        wr(3'd3, 8'h08);
        chk({7'd0, prog_open_o}, 8'h00, "R8 prog relocked");
        chk({7'd0, data_open_o}, 8'h01, "R8 data kept");
        wr(3'd3, 8'h00);
        rd(3'd3, 8'h40, "R8 both relocked");
        wr(3'd3, 8'h0A);
        rd(3'd3, 8'h40, "R8 set bits no effect");
        wr(3'd4, 8'h56);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hAE);
        chk({7'd0, prog_open_o}, 8'h00, "R8 armed discarded");

        // R7 failed stays locked
        wr(3'd4, 8'h56);
        wr(3'd4, 8'hAE);
        chk({7'd0, prog_open_o}, 8'h00, "R7 prog failed");
        wr(3'd5, 8'hAE);
        wr(3'd5, 8'h11);
        wr(3'd5, 8'hAE);
        wr(3'd5, 8'h56);
        chk({7'd0, data_open_o}, 8'h00, "R7 data failed");
        rd(3'd3, 8'h40, "R7 status locked");

        // R9 read clears flags
        pulse(1'b1, 1'b0);
        rd(3'd3, 8'h44, "R9 eop seen");
        rd(3'd3, 8'h40, "R9 eop cleared");
        pulse(1'b0, 1'b1);
        rd(3'd3, 8'h41, "R9 wrdis seen");
        rd(3'd3, 8'h40, "R9 wrdis cleared");
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd3; eop_set_i = 1'b1;
        exp_q.push_back(8'h40); tag_q.push_back("R9 same-cycle old value");
        @(negedge clk);
        bus_en = 1'b0; eop_set_i = 1'b0;
        rd(3'd3, 8'h44, "R9 set wins");
        rd(3'd3, 8'h40, "R9 cleared after");

        // R10 interrupt
        wr(3'd0, 8'h02);
        rd(3'd0, 8'h02, "R10 ctrl readback");
        chk({7'd0, irq_o}, 8'h00, "R10 no flag");
        pulse(1'b1, 1'b0);
        chk({7'd0, irq_o}, 8'h01, "R10 irq on eop");
        rd(3'd3, 8'h44, "R10 status");
        chk({7'd0, irq_o}, 8'h00, "R10 irq cleared");
        wr(3'd0, 8'h00);
        pulse(1'b0, 1'b1);
        chk({7'd0, irq_o}, 8'h00, "R10 masked");
        wr(3'd0, 8'h02);
        chk({7'd0, irq_o}, 8'h01, "R10 unmasked");
        rd(3'd3, 8'h41, "R10 status wrdis");
        chk({7'd0, irq_o}, 8'h00, "R10 cleared again");
        rd(3'd7, 8'h00, "R11 unused offset");

        // R7 reset recovers failed area
        do_reset();
        wr(3'd4, 8'h56);
        wr(3'd4, 8'hAE);
        chk({7'd0, prog_open_o}, 8'h01, "R7 open after reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 reads pending actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule